// File: doc/BRIEF.md
# Pipelined Synchronous SRAM with Late-Write Data Phase

This block models a single-port synchronous SRAM with one shared data bus. Reads and writes can follow each other on every enabled clock, in any mix, without idle cycles. This works because a write's data is taken in the same pipeline slot where a read's data would leave. A command (load or burst advance) is captured on one edge. Its array access and output register update happen on the next edge. Write data is taken on the edge after that. The bus therefore carries the data of the command issued two enabled clocks earlier, in whichever direction that command needs.

Three chip selects qualify each load. A write enable and two active-low lane strobes select the operation and the byte lanes. A two-bit burst counter continues a loaded command in linear or interleaved order. An active-high clock enable freezes the whole pipeline. An asynchronous output enable gates the bus driver. The array depth is a parameter, so a small memory can be used for full sweeps. A read that overtakes a write to the same word, while that write is still waiting for its data, returns the write data merged per lane.

Top module: `pipe_sram`

## Requirements
- R1: Synchronous reset clears the pipeline. After reset `bus_drive` is 0 and `bus_out` is 0.
- R2: A read load is captured on enabled edge n. After enabled edge n+1, `bus_out` holds the stored word, and `bus_drive` is 1 while `out_en_n` is 0.
- R3: A write load is captured on enabled edge n. Its data is taken from `bus_in` on enabled edge n+2. Between those edges `bus_drive` is 0.
- R4: The word has two lanes: lane 0 is bits 8:0 and lane 1 is bits 17:9. A write changes lane i only if `lane_wr_n[i]` is 0 in the cycle that issues that write beat. Other lanes keep their contents.
- R5: A load is an operation only if `sel_a_n`=0, `sel_b`=1 and `sel_c_n`=0. Otherwise it is a deselect: nothing is written and the bus is not driven in its data slot.
- R6: With `burst_next`=1, the last loaded command continues, and `sel_*`, `wr_n`, `addr` and `ilv_order` are ignored. Beat k (k=1..3, counting mod 4) uses the loaded address with its two low bits replaced by (base+k) mod 4 when linear order was chosen.
- R7: `ilv_order` is sampled on a load: 1 selects interleaved order, where the low two bits of beat k are base XOR k. 0 selects linear order.
- R8: With `clk_en`=0, an edge changes no state: `bus_out` and `bus_drive` stay the same, no command is accepted, and `bus_in` is not taken.
- R9: `out_en_n`=1 forces `bus_drive` to 0 without waiting for a clock.
- R10: A read issued on the cycle after a write to the same address returns the write's new lanes merged with the old contents of the unwritten lanes.
- R11: Reads and writes may alternate on consecutive enabled cycles with no idle cycle, and each returns or stores the correct data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| clk_en | input | 1 | Clock enable, active high; 0 freezes all state |
| addr | input | ADDR_W | Word address for a load |
| burst_next | input | 1 | 0 loads a new command, 1 advances the burst |
| sel_a_n | input | 1 | Chip select, active low |
| sel_b | input | 1 | Chip select, active high |
| sel_c_n | input | 1 | Chip select, active low |
| wr_n | input | 1 | 0 for write, 1 for read, on a load |
| lane_wr_n | input | LANES | Per-lane write strobes, active low |
| ilv_order | input | 1 | Burst order on a load: 1 interleaved, 0 linear |
| out_en_n | input | 1 | Asynchronous output enable, active low |
| bus_in | input | LANES*LANE_W | Write data, inbound side of the shared bus |
| bus_out | output | LANES*LANE_W | Read data, outbound side of the shared bus |
| bus_drive | output | 1 | High when the block drives the bus |

## Verification
The assertions assume that reset is applied before the first command, so that every slot in flight is known. They also assume that an advance is only used after a selected load, so the kind of the slot comes from a load seen since reset. The driver beats follow both rules: it always resets first and only starts bursts with a selected load. During the stall cycles it holds `out_en_n` low, so the bus drive flag can only change through pipeline state.

// File: rtl/pipe_sram_pkg.sv
package pipe_sram_pkg;
  typedef enum logic [1:0] {
    OP_IDLE  = 2'd0,
    OP_READ  = 2'd1,
    OP_WRITE = 2'd2
  } op_e;
endpackage

// File: rtl/pipe_sram_cmd.sv
// Command stage: decodes loads, runs the burst counter and registers the
// effective address, operation and lane strobes of every enabled cycle.
module pipe_sram_cmd
  import pipe_sram_pkg::*;
#(
  parameter int ADDR_W  = 8,
  parameter int LANES   = 2,
  parameter int BURST_W = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              en,
  input  logic              advance,
  input  logic              sel_ok,
  input  logic              wr_n,
  input  logic [LANES-1:0]  lane_wr_n,
  input  logic              ilv,
  input  logic [ADDR_W-1:0] addr,
  output op_e               op_q,
  output logic [ADDR_W-1:0] addr_q,
  output logic [LANES-1:0]  mask_q
);
  logic [ADDR_W-1:0]  base_q;
  logic               ilv_q;
  logic [BURST_W-1:0] cnt_q;
  logic [BURST_W-1:0] cnt_nx;
  logic [BURST_W-1:0] low_nx;
  op_e                kind_q;
  op_e                load_kind;

  assign cnt_nx    = cnt_q + BURST_W'(1);
  assign load_kind = !sel_ok ? OP_IDLE : (wr_n ? OP_READ : OP_WRITE);

  // low address bits of the next beat
  always_comb begin
    if (ilv_q) low_nx = base_q[BURST_W-1:0] ^ cnt_nx;
    else       low_nx = base_q[BURST_W-1:0] + cnt_nx;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      kind_q <= OP_IDLE;
      op_q   <= OP_IDLE;
      base_q <= '0;
      ilv_q  <= 1'b0;
      cnt_q  <= '0;
      addr_q <= '0;
      mask_q <= '0;
    end else if (en) begin
      mask_q <= ~lane_wr_n;
      if (!advance) begin
        base_q <= addr;
        ilv_q  <= ilv;
        cnt_q  <= '0;
        kind_q <= load_kind;
        op_q   <= load_kind;
        addr_q <= addr;
      end else begin
        cnt_q  <= cnt_nx;
        op_q   <= kind_q;
        addr_q <= {base_q[ADDR_W-1:BURST_W], low_nx};
      end
    end
  end
endmodule

// File: rtl/pipe_sram_array.sv
// Storage: one simple dual-port array per lane, registered read port,
// read-before-write on a shared address.
module pipe_sram_array #(
  parameter int ADDR_W = 8,
  parameter int LANES  = 2,
  parameter int LANE_W = 9
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    en,
  input  logic [ADDR_W-1:0]       rd_addr,
  input  logic [ADDR_W-1:0]       wr_addr,
  input  logic [LANES-1:0]        wr_lane,
  input  logic [LANES*LANE_W-1:0] wr_data,
  output logic [LANES*LANE_W-1:0] rd_data
);
  localparam int DEPTH = 1 << ADDR_W;

  for (genvar l = 0; l < LANES; l++) begin : g_lane
    logic [LANE_W-1:0] mem [DEPTH];

    always_ff @(posedge clk) begin
      if (en && wr_lane[l]) mem[wr_addr] <= wr_data[l*LANE_W +: LANE_W];
    end

    always_ff @(posedge clk) begin
      if (rst)     rd_data[l*LANE_W +: LANE_W] <= '0;
      else if (en) rd_data[l*LANE_W +: LANE_W] <= mem[rd_addr];
    end
  end
endmodule

// File: rtl/pipe_sram_data.sv
// Data stage: holds the slot whose data is on the bus, steers write data
// into the array, captures the overtaking-read bypass and drives the bus.
module pipe_sram_data
  import pipe_sram_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int LANES  = 2,
  parameter int LANE_W = 9
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    en,
  input  op_e                     s1_op,
  input  logic [ADDR_W-1:0]       s1_addr,
  input  logic [LANES-1:0]        s1_mask,
  input  logic [LANES*LANE_W-1:0] bus_in,
  input  logic [LANES*LANE_W-1:0] rd_data,
  input  logic                    out_en_n,
  output logic [ADDR_W-1:0]       wr_addr,
  output logic [LANES-1:0]        wr_lane,
  output logic [LANES*LANE_W-1:0] wr_data,
  output logic [LANES*LANE_W-1:0] bus_out,
  output logic                    bus_drive
);
  localparam int DATA_W = LANES * LANE_W;

  op_e               s2_op;
  logic [ADDR_W-1:0] s2_addr;
  logic [LANES-1:0]  s2_mask;
  logic [LANES-1:0]  byp_lane;
  logic [DATA_W-1:0] byp_data;
  logic              hit;

  assign hit     = (s1_op == OP_READ) && (s2_op == OP_WRITE) && (s1_addr == s2_addr);
  assign wr_addr = s2_addr;
  assign wr_data = bus_in;
  assign wr_lane = (s2_op == OP_WRITE) ? s2_mask : '0;

  always_ff @(posedge clk) begin
    if (rst) begin
      s2_op    <= OP_IDLE;
      s2_addr  <= '0;
      s2_mask  <= '0;
      byp_lane <= '0;
      byp_data <= '0;
    end else if (en) begin
      s2_op    <= s1_op;
      s2_addr  <= s1_addr;
      s2_mask  <= s1_mask;
      byp_lane <= hit ? s2_mask : '0;
      byp_data <= bus_in;
    end
  end

  for (genvar l = 0; l < LANES; l++) begin : g_mux
    assign bus_out[l*LANE_W +: LANE_W] = byp_lane[l] ? byp_data[l*LANE_W +: LANE_W]
                                                     : rd_data[l*LANE_W +: LANE_W];
  end

  assign bus_drive = (s2_op == OP_READ) && !out_en_n;
endmodule

// File: rtl/pipe_sram.sv
module pipe_sram
  import pipe_sram_pkg::*;
#(
  parameter int ADDR_W  = 8,
  parameter int LANES   = 2,
  parameter int LANE_W  = 9,
  parameter int BURST_W = 2
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    clk_en,
  input  logic [ADDR_W-1:0]       addr,
  input  logic                    burst_next,
  input  logic                    sel_a_n,
  input  logic                    sel_b,
  input  logic                    sel_c_n,
  input  logic                    wr_n,
  input  logic [LANES-1:0]        lane_wr_n,
  input  logic                    ilv_order,
  input  logic                    out_en_n,
  input  logic [LANES*LANE_W-1:0] bus_in,
  output logic [LANES*LANE_W-1:0] bus_out,
  output logic                    bus_drive
);
  localparam int DATA_W = LANES * LANE_W;

  op_e               s1_op;
  logic [ADDR_W-1:0] s1_addr;
  logic [LANES-1:0]  s1_mask;
  logic [ADDR_W-1:0] wr_addr;
  logic [LANES-1:0]  wr_lane;
  logic [DATA_W-1:0] wr_data;
  logic [DATA_W-1:0] rd_data;
  logic              sel_ok;

  assign sel_ok = !sel_a_n && sel_b && !sel_c_n;

  pipe_sram_cmd #(.ADDR_W(ADDR_W), .LANES(LANES), .BURST_W(BURST_W)) u_cmd (
    .clk      (clk),
    .rst      (rst),
    .en       (clk_en),
    .advance  (burst_next),
    .sel_ok   (sel_ok),
    .wr_n     (wr_n),
    .lane_wr_n(lane_wr_n),
    .ilv      (ilv_order),
    .addr     (addr),
    .op_q     (s1_op),
    .addr_q   (s1_addr),
    .mask_q   (s1_mask)
  );

  pipe_sram_array #(.ADDR_W(ADDR_W), .LANES(LANES), .LANE_W(LANE_W)) u_array (
    .clk    (clk),
    .rst    (rst),
    .en     (clk_en),
    .rd_addr(s1_addr),
    .wr_addr(wr_addr),
    .wr_lane(wr_lane),
    .wr_data(wr_data),
    .rd_data(rd_data)
  );

  pipe_sram_data #(.ADDR_W(ADDR_W), .LANES(LANES), .LANE_W(LANE_W)) u_data (
    .clk      (clk),
    .rst      (rst),
    .en       (clk_en),
    .s1_op    (s1_op),
    .s1_addr  (s1_addr),
    .s1_mask  (s1_mask),
    .bus_in   (bus_in),
    .rd_data  (rd_data),
    .out_en_n (out_en_n),
    .wr_addr  (wr_addr),
    .wr_lane  (wr_lane),
    .wr_data  (wr_data),
    .bus_out  (bus_out),
    .bus_drive(bus_drive)
  );
endmodule

// File: rtl/pipe_sram_chk.sv
module pipe_sram_chk #(
  parameter int DATA_W = 18
) (
  input logic              clk,
  input logic              rst,
  input logic              clk_en,
  input logic              burst_next,
  input logic              sel_a_n,
  input logic              sel_b,
  input logic              sel_c_n,
  input logic              wr_n,
  input logic              out_en_n,
  input logic [DATA_W-1:0] bus_out,
  input logic              bus_drive
);
  logic sel_ok;
  assign sel_ok = !sel_a_n && sel_b && !sel_c_n;

  p_rd_drive_r2: assert property (@(posedge clk) disable iff (rst)
    (clk_en && !burst_next && sel_ok && wr_n ##1 clk_en ##1 !out_en_n) |-> bus_drive);

  p_wr_float_r3: assert property (@(posedge clk) disable iff (rst)
    (clk_en && !burst_next && sel_ok && !wr_n ##1 clk_en) |=> !bus_drive);

  p_desel_float_r5: assert property (@(posedge clk) disable iff (rst)
    (clk_en && !burst_next && !sel_ok ##1 clk_en) |=> !bus_drive);

  p_stall_hold_r8: assert property (@(posedge clk) disable iff (rst)
    !clk_en |=> $stable(bus_out));
endmodule

bind pipe_sram pipe_sram_chk #(.DATA_W(LANES*LANE_W)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .clk_en    (clk_en),
  .burst_next(burst_next),
  .sel_a_n   (sel_a_n),
  .sel_b     (sel_b),
  .sel_c_n   (sel_c_n),
  .wr_n      (wr_n),
  .out_en_n  (out_en_n),
  .bus_out   (bus_out),
  .bus_drive (bus_drive)
);

// File: tb/sim_pipe_sram.sv
`timescale 1ns/1ps
module sim_pipe_sram;
  localparam int AW = 6;
  localparam int NW = 1 << AW;

  logic          clk = 1'b0;
  logic          rst, clk_en, burst_next, sel_a_n, sel_b, sel_c_n, wr_n, ilv_order, out_en_n;
  logic [AW-1:0] addr;
  logic [1:0]    lane_wr_n;
  logic [17:0]   bus_in;
  logic [17:0]   bus_out;
  logic          bus_drive;

  pipe_sram #(.ADDR_W(AW), .LANES(2), .LANE_W(9), .BURST_W(2)) u0 (
    .clk(clk), .rst(rst), .clk_en(clk_en), .addr(addr), .burst_next(burst_next),
    .sel_a_n(sel_a_n), .sel_b(sel_b), .sel_c_n(sel_c_n), .wr_n(wr_n),
    .lane_wr_n(lane_wr_n), .ilv_order(ilv_order), .out_en_n(out_en_n),
    .bus_in(bus_in), .bus_out(bus_out), .bus_drive(bus_drive)
  );

  always #2 clk = ~clk;

  int          n_chk = 0;
  int          n_err = 0;
  bit          done  = 0;
  bit          probe = 0;
  logic [17:0] ref_m [NW];
  int          hk [2];
  int          ha [2];
  logic [1:0]  hb [2];
  logic [17:0] hd [2];
  string       ht [2];
  int          b_base, b_k, b_kind;
  bit          b_ilv;

  function automatic logic [17:0] pat(input int a, input int s);
    return 18'((a * 2897 + s * 40503) ^ (a << 11) ^ (s << 5));
  endfunction

  task automatic chk(input bit ok, input string tg, input logic [17:0] act, input logic [17:0] exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s actual=%h expected=%h", tg, act, exp);
    end
  endtask

  // One enabled cycle: new command inputs are already set by the caller.
  task automatic tick(input int k, input int ea, input logic [1:0] bw,
                      input logic [17:0] d, input string tg);
    logic [17:0] m;
    clk_en = 1'b1;
    bus_in = hd[1];
    if (hk[1] == 2) begin
      m = ref_m[ha[1]];
      if (!hb[1][0]) m[8:0]  = hd[1][8:0];
      if (!hb[1][1]) m[17:9] = hd[1][17:9];
      ref_m[ha[1]] = m;
    end
    if (hk[1] == 1)
      chk(bus_drive === 1'b1 && bus_out === ref_m[ha[1]], ht[1], bus_out, ref_m[ha[1]]);
    else
      chk(bus_drive === 1'b0, ht[1], {17'b0, bus_drive}, 18'h0);
    if (probe && hk[1] == 1) begin
      out_en_n = 1'b1; #1;
      chk(bus_drive === 1'b0, "R9 drive off with out_en_n high", {17'b0, bus_drive}, 18'h0);
      out_en_n = 1'b0; #1;
      chk(bus_drive === 1'b1, "R9 drive back with out_en_n low", {17'b0, bus_drive}, 18'h1);
    end
    hk[1] = hk[0]; ha[1] = ha[0]; hb[1] = hb[0]; hd[1] = hd[0]; ht[1] = ht[0];
    hk[0] = k;     ha[0] = ea;    hb[0] = bw;    hd[0] = d;     ht[0] = tg;
    @(posedge clk); #1;
  endtask

  task automatic do_load(input bit w, input int a, input logic [1:0] bw,
                         input logic [17:0] d, input bit ilv, input string tg);
    burst_next = 1'b0; sel_a_n = 1'b0; sel_b = 1'b1; sel_c_n = 1'b0;
    wr_n = !w; addr = a[AW-1:0]; lane_wr_n = bw; ilv_order = ilv;
    b_base = a; b_ilv = ilv; b_k = 0; b_kind = w ? 2 : 1;
    tick(b_kind, a, bw, d, tg);
  endtask

  task automatic do_adv(input logic [1:0] bw, input logic [17:0] d, input string tg);
    int lo;
    burst_next = 1'b1; sel_a_n = 1'b1; sel_b = 1'b0; sel_c_n = 1'b1;
    wr_n = ~wr_n; addr = ~addr; ilv_order = !b_ilv; lane_wr_n = bw;
    b_k = (b_k + 1) % 4;
    lo  = b_ilv ? ((b_base & 3) ^ b_k) : (((b_base & 3) + b_k) & 3);
    tick(b_kind, (b_base & ~3) | lo, bw, d, tg);
  endtask

  task automatic do_desel(input int which, input int a, input string tg);
    burst_next = 1'b0; sel_a_n = (which == 0); sel_b = (which != 1); sel_c_n = (which == 2);
    wr_n = 1'b0; addr = a[AW-1:0]; lane_wr_n = 2'b00;
    b_kind = 0;
    tick(0, a, 2'b00, 18'h2AAAA ^ 18'(a), tg);
  endtask

  task automatic stall_tick(input string tg);
    logic [17:0] so;
    logic        sd;
    clk_en = 1'b0; so = bus_out; sd = bus_drive; bus_in = ~hd[1];
    burst_next = 1'b0; sel_a_n = 1'b0; sel_b = 1'b1; sel_c_n = 1'b0;
    wr_n = 1'b0; addr = ~addr; lane_wr_n = 2'b00;
    @(posedge clk); #1;
    chk(bus_out === so && bus_drive === sd, tg, bus_out, so);
    clk_en = 1'b1;
  endtask

  initial begin
    #(4 * 200000);
    if (!done) begin
      n_chk++; n_err++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end

  initial begin
    rst = 1'b1; clk_en = 1'b1; burst_next = 1'b0; sel_a_n = 1'b1; sel_b = 1'b0; sel_c_n = 1'b1;
    wr_n = 1'b1; ilv_order = 1'b0; out_en_n = 1'b0; addr = '0; lane_wr_n = 2'b11; bus_in = '0;
    for (int i = 0; i < 2; i++) begin
      hk[i] = 0; ha[i] = 0; hb[i] = 2'b11; hd[i] = 18'h15555; ht[i] = "R1 idle after reset";
    end
    repeat (3) @(posedge clk);
    #1 rst = 1'b0;
    chk(bus_drive === 1'b0 && bus_out === 18'h0, "R1 reset state", bus_out, 18'h0);

    // R3 write sweep, R2 read sweep
    for (int a = 0; a < NW; a++) do_load(1, a, 2'b00, pat(a, 1), 0, "R3 sweep write");
    for (int a = 0; a < NW; a++) do_load(0, a, 2'b11, 18'h0, 0, "R2 sweep read");

    // R4 lanes, R10 overtaking read, R11 alternation
    for (int a = 0; a < 32; a++) begin
      do_load(1, a, 2'(a % 4), pat(a, 2), 0, "R4 lane strobed write");
      do_load(0, a, 2'b11, 18'h0, 0, "R10 read right after write");
      do_load(0, (a + 1) % NW, 2'b11, 18'h0, 0, "R11 read after read");
      do_load(1, (a + 40) % NW, 2'b00, pat(a, 3), 0, "R11 write after read");
    end

    // R6 linear and R7 interleaved bursts
    for (int il = 0; il < 2; il++) begin
      for (int base = 16; base < 24; base++) begin
        do_load(1, base, 2'b00, pat(base, 4 + il), il[0], il ? "R7 ilv burst write" : "R6 lin burst write");
        for (int k = 1; k < 4; k++)
          do_adv(2'(k % 3), pat(base + k, 6 + il), il ? "R7 ilv burst write" : "R6 lin burst write");
        do_load(0, base, 2'b11, 18'h0, il[0], il ? "R7 ilv burst read" : "R6 lin burst read");
        for (int k = 1; k < 4; k++)
          do_adv(2'b11, 18'h0, il ? "R7 ilv burst read" : "R6 lin burst read");
      end
    end

    // R5 deselects do not write or drive
    for (int w = 0; w < 3; w++) do_desel(w, 50, "R5 deselect cycle");
    do_desel(0, 0, "R5 idle");
    do_desel(0, 0, "R5 idle");
    do_load(0, 50, 2'b11, 18'h0, 0, "R5 deselected write left word intact");

    // R8 clock enable holds everything
    do_load(1, 7, 2'b00, pat(7, 9), 0, "R8 write around stalls");
    stall_tick("R8 hold after write load");
    do_load(0, 9, 2'b11, 18'h0, 0, "R8 read around stalls");
    stall_tick("R8 hold in write data slot");
    do_load(0, 7, 2'b11, 18'h0, 0, "R8 read of stalled write");
    stall_tick("R8 hold in read data slot");
    stall_tick("R8 second hold in read data slot");
    do_desel(0, 0, "R8 idle");
    do_desel(0, 0, "R8 idle");

    // R9 asynchronous output enable
    probe = 1;
    do_load(0, 3, 2'b11, 18'h0, 0, "R9 read for drive probe");
    do_load(0, 4, 2'b11, 18'h0, 0, "R9 read for drive probe");
    do_desel(0, 0, "R9 idle");
    do_desel(0, 0, "R9 idle");
    probe = 0;

    // final sweep confirms placement of all earlier writes
    for (int a = 0; a < NW; a++) do_load(0, a, 2'b11, 18'h0, 0, "R4 final sweep read");
    do_desel(0, 0, "R2 drain");
    do_desel(0, 0, "R2 drain");

    done = 1;
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule